// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Port Master

This block loads a target FPGA through its byte-wide slave configuration port. It drives the target's program pin (`prog_b_o`), chip select (`cs_b_o`), write-direction (`rdwr_b_o`), configuration clock (`cclk_o`) and an 8-bit data bus. It watches the target's init (`init_b_i`) and done (`done_i`) pins. A start request runs the reset handshake in this order:

- If the port is still open from an earlier attempt, it is first aborted.
- The program pin is pulsed low for a timed interval.
- The init pin is polled for a bounded number of intervals.
- If init rises in time, the write port is opened and `begin_ok_o` is reported. Otherwise `begin_fail_o` is reported.

While the port is open, bytes arrive on a valid/ready stream. Each byte goes onto the bus and is followed by exactly one low-then-high clock pulse. The target samples the byte on the rising edge.

A finish request issues a fixed tail of startup clocks and then closes the port. It samples the done pin and reports `end_ok_o` or `end_fail_o`. All delays come from one prescaler, set by the number of system clocks per microsecond.

The controller states and their transitions are:

- IDLE to ABORT_RW on a start request when the port is open; IDLE to PROG_LOW when the port is closed.
- ABORT_RW to ABORT_CLK.
- ABORT_CLK to ABORT_CS after the abort pulses.
- ABORT_CS to PROG_LOW.
- PROG_LOW to INIT_WAIT when the pulse time expires.
- INIT_WAIT to OPEN on a poll that sees init high. INIT_WAIT to BEGIN_FAIL on the last unsuccessful poll. INIT_WAIT stays in INIT_WAIT on any other poll.
- OPEN to XFER.
- BEGIN_FAIL to IDLE.
- XFER to ABORT_RW on a start request, and XFER to TAIL on a finish request. Both are taken only when no pulse is in flight.
- TAIL to CLOSE after the startup pulses.
- CLOSE to CHECK.
- CHECK to IDLE.

Top module: `slave_cfg_master`

## Requirements
- R1: After reset the program, chip-select and write-direction pins and the clock are high, and `busy_o`, `in_ready_o` and all four result flags are low.
- R2: A start request drives `prog_b_o` low for between PROG_US*CLK_PER_US and PROG_US*CLK_PER_US+2 system clocks, then releases it. The chip select is high whenever `prog_b_o` is low.
- R3: If `init_b_i` is still low at all POLL_MAX polls, spaced POLL_US microseconds apart, the block pulses `begin_fail_o` for one cycle. It leaves the port closed and issues no clock pulse.
- R4: When a poll sees `init_b_i` high, the block drives `cs_b_o` and `rdwr_b_o` low and pulses `begin_ok_o` in the same cycle.
- R5: The block captures each accepted byte (`in_valid_i` and `in_ready_o` both high) onto `data_o` before its clock pulse. `data_o` holds steady while the clock is low. The value on the bus at each rising clock edge is the byte stream, in order.
- R6: Every low phase and every high phase that ends in a falling clock edge lasts at least CCLK_HALF system clocks.
- R7: `in_ready_o` is high only while the port is open for transfer. It rises exactly once for each completed data clock pulse.
- R8: A finish request produces exactly TAIL_CLKS clock pulses, then drives `cs_b_o` and `rdwr_b_o` high. After that the block reports `end_ok_o` if `done_i` is high.
- R9: If `done_i` is low when sampled after the port closes, the block pulses `end_fail_o` instead of `end_ok_o`.
- R10: A start request while the port is open first drives `rdwr_b_o` high. It then gives ABORT_CLKS clock pulses with `cs_b_o` still low, and then drives `cs_b_o` high. All of this happens before `prog_b_o` falls.
- R11: At most one of the four result flags is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| begin_req_i | input | 1 | Start request pulse |
| end_req_i | input | 1 | Finish request pulse |
| in_data_i | input | DATA_W | Configuration byte |
| in_valid_i | input | 1 | Byte valid |
| in_ready_o | output | 1 | Byte sent; handshake completes this cycle |
| init_b_i | input | 1 | Target init pin |
| done_i | input | 1 | Target done pin |
| busy_o | output | 1 | Sequence in progress (not idle, not accepting bytes) |
| begin_ok_o | output | 1 | Port opened |
| begin_fail_o | output | 1 | Init timed out |
| end_ok_o | output | 1 | Done seen high |
| end_fail_o | output | 1 | Done seen low |
| prog_b_o | output | 1 | Target program pin |
| cs_b_o | output | 1 | Target chip select |
| rdwr_b_o | output | 1 | Target write-direction |
| cclk_o | output | 1 | Configuration clock |
| data_o | output | DATA_W | Configuration data bus |

## Verification
The program pulse is measured in clock cycles and must fall in a window three cycles wide. Its nominal length is PROG_US*CLK_PER_US. One cycle is added for the timer load and another for its registered expiry.

Each byte's ready pulse arrives 2*CCLK_HALF+1 cycles after the byte is taken. The bench waits for that pulse, sampling on the falling system-clock edge, rather than assuming a fixed cycle count. The bench samples bus values and pin levels on the first falling edge after each rising configuration-clock edge. It counts pulses between protocol events: from the start request to the program pin falling, and from the finish request to the result flag. The result flags and the port-open levels appear one cycle after the state that produces them. The bench waits for the flag and checks the pins in that same sample.

// File: rtl/cfgm_pkg.sv
package cfgm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ABORT_RW,
        ST_ABORT_CLK,
        ST_ABORT_CS,
        ST_PROG_LOW,
        ST_INIT_WAIT,
        ST_OPEN,
        ST_BEGIN_FAIL,
        ST_XFER,
        ST_TAIL,
        ST_CLOSE,
        ST_CHECK
    } ctl_state_t;

    typedef enum logic [1:0] {
        CG_IDLE,
        CG_LOW,
        CG_HIGH
    } cg_state_t;

endpackage

// File: rtl/cfgm_timer.sv
module cfgm_timer #(
    parameter int CLK_PER_US = 50,
    parameter int LEN_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_us_i,
    output logic             expired_o
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [LEN_W-1:0] left_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q     <= '0;
            left_q    <= '0;
            run_q     <= 1'b0;
            expired_o <= 1'b0;
        end else begin
            expired_o <= 1'b0;
            if (load_i) begin
                pre_q  <= '0;
                left_q <= len_us_i;
                run_q  <= 1'b1;
            end else if (run_q) begin
                if (pre_q == PRE_W'(CLK_PER_US - 1)) begin
                    pre_q <= '0;
                    if (left_q <= LEN_W'(1)) begin
                        run_q     <= 1'b0;
                        expired_o <= 1'b1;
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end

    AST_EXPIRE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |-> $past(run_q)); // R2

endmodule

// File: rtl/cfgm_cclk_gen.sv
module cfgm_cclk_gen
    import cfgm_pkg::*;
#(
    parameter int CCLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic cclk_o
);
    localparam int CNT_W = (CCLK_HALF > 1) ? $clog2(CCLK_HALF) : 1;
    localparam int MON_W = $clog2(CCLK_HALF + 2);

    cg_state_t        st_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CG_IDLE;
            cnt_q  <= '0;
            cclk_o <= 1'b1;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (st_q)
                CG_IDLE: begin
                    if (start_i) begin
                        st_q   <= CG_LOW;
                        cnt_q  <= CNT_W'(CCLK_HALF - 1);
                        cclk_o <= 1'b0;
                    end
                end
                CG_LOW: begin
                    if (cnt_q == '0) begin
                        st_q   <= CG_HIGH;
                        cnt_q  <= CNT_W'(CCLK_HALF - 1);
                        cclk_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                CG_HIGH: begin
                    if (cnt_q == '0) begin
                        st_q   <= CG_IDLE;
                        done_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= CG_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q != CG_IDLE);

    // Phase-width monitors, saturating, independent of the phase counter
    logic [MON_W-1:0] lo_run_q, hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_run_q <= '0;
            hi_run_q <= MON_W'(CCLK_HALF);
        end else if (cclk_o) begin
            lo_run_q <= '0;
            if (hi_run_q < MON_W'(CCLK_HALF)) hi_run_q <= hi_run_q + 1'b1;
        end else begin
            hi_run_q <= '0;
            if (lo_run_q < MON_W'(CCLK_HALF)) lo_run_q <= lo_run_q + 1'b1;
        end
    end

    AST_CCLK_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cclk_o && !$past(cclk_o)) |-> ($past(lo_run_q) >= MON_W'(CCLK_HALF - 1))); // R6
    AST_CCLK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cclk_o && $past(cclk_o)) |-> ($past(hi_run_q) >= MON_W'(CCLK_HALF - 1))); // R6

endmodule

// File: rtl/slave_cfg_master.sv
module slave_cfg_master
    import cfgm_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CLK_PER_US = 50,
    parameter int PROG_US    = 100,
    parameter int POLL_US    = 1000,
    parameter int POLL_MAX   = 50,
    parameter int CCLK_HALF  = 2,
    parameter int TAIL_CLKS  = 4,
    parameter int ABORT_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_req_i,
    input  logic              end_req_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic              init_b_i,
    input  logic              done_i,
    output logic              busy_o,
    output logic              begin_ok_o,
    output logic              begin_fail_o,
    output logic              end_ok_o,
    output logic              end_fail_o,
    output logic              prog_b_o,
    output logic              cs_b_o,
    output logic              rdwr_b_o,
    output logic              cclk_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int MAX_US = (PROG_US > POLL_US) ? PROG_US : POLL_US;
    localparam int US_W   = $clog2(MAX_US + 1);
    localparam int POLL_W = $clog2(POLL_MAX + 1);
    localparam int MAX_PC = (TAIL_CLKS > ABORT_CLKS) ? TAIL_CLKS : ABORT_CLKS;
    localparam int PC_W   = $clog2(MAX_PC + 1);

    ctl_state_t       state_q, state_d;
    logic             tmr_load, tmr_exp;
    logic [US_W-1:0]  tmr_len;
    logic             cg_start, cg_busy, cg_done;
    logic [PC_W-1:0]  pulse_cnt_q;
    logic [POLL_W-1:0] poll_cnt_q;
    logic             pulse_idle;

    cfgm_timer #(.CLK_PER_US(CLK_PER_US), .LEN_W(US_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .len_us_i  (tmr_len),
        .expired_o (tmr_exp)
    );

    cfgm_cclk_gen #(.CCLK_HALF(CCLK_HALF)) u_cclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cg_start),
        .busy_o  (cg_busy),
        .done_o  (cg_done),
        .cclk_o  (cclk_o)
    );

    assign pulse_idle = !cg_busy && !cg_done && !in_ready_o;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state, timer and pulse requests
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_len  = US_W'(PROG_US);
        cg_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (begin_req_i) begin
                    if (!cs_b_o || !rdwr_b_o) begin
                        state_d = ST_ABORT_RW;
                    end else begin
                        state_d  = ST_PROG_LOW;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_ABORT_RW: state_d = ST_ABORT_CLK;
            ST_ABORT_CLK: begin
                if (pulse_idle) begin
                    if (pulse_cnt_q == PC_W'(ABORT_CLKS)) state_d = ST_ABORT_CS;
                    else                                  cg_start = 1'b1;
                end
            end
            ST_ABORT_CS: begin
                state_d  = ST_PROG_LOW;
                tmr_load = 1'b1;
            end
            ST_PROG_LOW: begin
                if (tmr_exp) begin
                    state_d  = ST_INIT_WAIT;
                    tmr_load = 1'b1;
                    tmr_len  = US_W'(POLL_US);
                end
            end
            ST_INIT_WAIT: begin
                if (tmr_exp) begin
                    if (init_b_i) begin
                        state_d = ST_OPEN;
                    end else if (poll_cnt_q == POLL_W'(POLL_MAX - 1)) begin
                        state_d = ST_BEGIN_FAIL;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_len  = US_W'(POLL_US);
                    end
                end
            end
            ST_OPEN:       state_d = ST_XFER;
            ST_BEGIN_FAIL: state_d = ST_IDLE;
            ST_XFER: begin
                if (pulse_idle) begin
                    if (begin_req_i)     state_d  = ST_ABORT_RW;
                    else if (end_req_i)  state_d  = ST_TAIL;
                    else if (in_valid_i) cg_start = 1'b1;
                end
            end
            ST_TAIL: begin
                if (pulse_idle) begin
                    if (pulse_cnt_q == PC_W'(TAIL_CLKS)) state_d = ST_CLOSE;
                    else                                 cg_start = 1'b1;
                end
            end
            ST_CLOSE: state_d = ST_CHECK;
            ST_CHECK: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Counters for pulse bursts and init polls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt_q <= '0;
            poll_cnt_q  <= '0;
        end else begin
            if (state_q != ST_ABORT_CLK && state_q != ST_TAIL) pulse_cnt_q <= '0;
            else if (cg_done)                                   pulse_cnt_q <= pulse_cnt_q + 1'b1;
            if (state_q != ST_INIT_WAIT) poll_cnt_q <= '0;
            else if (tmr_exp)            poll_cnt_q <= poll_cnt_q + 1'b1;
        end
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_b_o     <= 1'b1;
            cs_b_o       <= 1'b1;
            rdwr_b_o     <= 1'b1;
            data_o       <= '0;
            in_ready_o   <= 1'b0;
            begin_ok_o   <= 1'b0;
            begin_fail_o <= 1'b0;
            end_ok_o     <= 1'b0;
            end_fail_o   <= 1'b0;
        end else begin
            begin_ok_o   <= 1'b0;
            begin_fail_o <= 1'b0;
            end_ok_o     <= 1'b0;
            end_fail_o   <= 1'b0;
            in_ready_o   <= (state_q == ST_XFER) && cg_done;
            prog_b_o     <= (state_d != ST_PROG_LOW);
            if (state_q == ST_XFER && cg_start) data_o <= in_data_i;
            unique case (state_q)
                ST_ABORT_RW:   rdwr_b_o <= 1'b1;
                ST_ABORT_CS:   cs_b_o   <= 1'b1;
                ST_OPEN: begin
                    cs_b_o     <= 1'b0;
                    rdwr_b_o   <= 1'b0;
                    begin_ok_o <= 1'b1;
                end
                ST_BEGIN_FAIL: begin_fail_o <= 1'b1;
                ST_CLOSE: begin
                    cs_b_o   <= 1'b1;
                    rdwr_b_o <= 1'b1;
                end
                ST_CHECK: begin
                    end_ok_o   <= done_i;
                    end_fail_o <= !done_i;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE) && (state_q != ST_XFER);

    AST_PROG_PORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_b_o |-> cs_b_o); // R2
    AST_FAIL_PORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        begin_fail_o |-> (cs_b_o && rdwr_b_o)); // R3
    AST_OK_PORT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        begin_ok_o |-> (!cs_b_o && !rdwr_b_o && prog_b_o)); // R4
    AST_DATA_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!cclk_o && $past(!cclk_o)) |-> $stable(data_o)); // R5
    AST_READY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (state_q == ST_XFER)); // R7
    AST_END_PORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ok_o || end_fail_o) |-> (cs_b_o && rdwr_b_o)); // R8
    AST_ABORT_RW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT_CLK) |-> (rdwr_b_o && !cs_b_o)); // R10
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({begin_ok_o, begin_fail_o, end_ok_o, end_fail_o})); // R11

endmodule

// File: tb/tb_slave_cfg_master.sv
`timescale 1ns/100ps
module tb_slave_cfg_master;
    localparam int CPU = 2, PUS = 3, QUS = 4, QMAX = 3, HALF = 2, TAILN = 4, ABN = 4;
    localparam int PLEN = PUS * CPU;

    logic clk = 1'b0, rst_n = 1'b0;
    logic begin_req = 1'b0, end_req = 1'b0, in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic init_ok = 1'b0, done_lvl = 1'b0;
    logic in_ready, busy, b_ok, b_fail, e_ok, e_fail, prog_b, cs_b, rdwr_b, cclk;
    logic [7:0] data;
    logic init_b;

    int vecs = 0, fails = 0;

    always #2.5 clk = ~clk;
    assign init_b = init_ok & prog_b;

    slave_cfg_master #(.DATA_W(8), .CLK_PER_US(CPU), .PROG_US(PUS), .POLL_US(QUS),
        .POLL_MAX(QMAX), .CCLK_HALF(HALF), .TAIL_CLKS(TAILN), .ABORT_CLKS(ABN)) dut (
        .clk(clk), .rst_n(rst_n), .begin_req_i(begin_req), .end_req_i(end_req),
        .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .init_b_i(init_b), .done_i(done_lvl), .busy_o(busy), .begin_ok_o(b_ok),
        .begin_fail_o(b_fail), .end_ok_o(e_ok), .end_fail_o(e_fail),
        .prog_b_o(prog_b), .cs_b_o(cs_b), .rdwr_b_o(rdwr_b), .cclk_o(cclk), .data_o(data));

    // Monitors, sampled on the falling system-clock edge
    int rises = 0, readies = 0, prog_len = 0, last_prog_len = 0, rise_at_prog_fall = 0;
    int lo_run = 0, hi_run = 0, min_lo = 999, min_hi = 999;
    logic prev_cclk = 1'b1, prev_prog = 1'b1, cs_at_prog_fall = 1'b0;
    logic [7:0] cap_data [64];
    logic       cap_rdwr [64];
    logic       cap_cs   [64];

    always @(negedge clk) begin
        if (rst_n) begin
            if (cclk && !prev_cclk) begin
                cap_data[rises % 64] <= data;
                cap_rdwr[rises % 64] <= rdwr_b;
                cap_cs[rises % 64]   <= cs_b;
                rises <= rises + 1;
                if (lo_run < min_lo) min_lo <= lo_run;
            end
            if (!cclk && prev_cclk && hi_run < min_hi) min_hi <= hi_run;
            if (cclk) begin hi_run <= hi_run + 1; lo_run <= 0; end
            else      begin lo_run <= lo_run + 1; hi_run <= 0; end
            if (!prog_b) prog_len <= prog_len + 1;
            if (!prog_b && prev_prog) begin
                rise_at_prog_fall <= rises;
                cs_at_prog_fall   <= cs_b;
                prog_len          <= 1;
            end
            if (prog_b && !prev_prog) last_prog_len <= prog_len;
            if (in_ready) readies <= readies + 1;
            prev_cclk <= cclk;
            prev_prog <= prog_b;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_result(output logic okf, output logic failf);
        okf = 1'b0; failf = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (b_ok || e_ok)   begin okf = 1'b1; break; end
            if (b_fail || e_fail) begin failf = 1'b1; break; end
        end
    endtask

    task automatic pulse_begin();
        @(negedge clk); begin_req = 1'b1;
        @(negedge clk); begin_req = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_data = b;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(prog_b && cs_b && rdwr_b && cclk, "R1 pins high", {prog_b, cs_b, rdwr_b, cclk}, 15);
        chk(!busy && !in_ready && !b_ok && !b_fail && !e_ok && !e_fail, "R1 flags low",
            {busy, in_ready, b_ok, b_fail, e_ok, e_fail}, 0);
    endtask

    task automatic t_begin_fail();
        logic okf, failf;
        int r0;
        r0 = rises;
        init_ok = 1'b0;
        pulse_begin();
        wait_result(okf, failf);
        chk(failf && !okf, "R3 begin_fail", failf, 1);
        chk(cs_b && rdwr_b, "R3 port closed", {cs_b, rdwr_b}, 3);
        chk(rises == r0, "R3 no clock pulses", rises - r0, 0);
        chk(last_prog_len >= PLEN && last_prog_len <= PLEN + 2, "R2 prog low width",
            last_prog_len, PLEN);
    endtask

    task automatic t_begin_ok();
        logic okf, failf;
        init_ok = 1'b1;
        pulse_begin();
        wait_result(okf, failf);
        chk(okf, "R4 begin_ok", okf, 1);
        chk(!cs_b && !rdwr_b, "R4 port open", {cs_b, rdwr_b}, 0);
    endtask

    task automatic t_stream(input int n, input logic [7:0] seed);
        int r0, q0;
        logic [7:0] b;
        r0 = rises; q0 = readies;
        for (int i = 0; i < n; i++) begin
            b = seed ^ 8'(i * 37);
            send_byte(b);
        end
        @(negedge clk);
        chk(readies - q0 == n, "R7 one ready per byte", readies - q0, n);
        chk(rises - r0 == n, "R5 one pulse per byte", rises - r0, n);
        for (int i = 0; i < n; i++) begin
            b = seed ^ 8'(i * 37);
            chk(cap_data[(r0 + i) % 64] == b, "R5 byte at rising edge",
                cap_data[(r0 + i) % 64], b);
        end
        chk(min_lo >= HALF, "R6 low phase width", min_lo, HALF);
        chk(min_hi >= HALF, "R6 high phase width", min_hi, HALF);
    endtask

    task automatic t_end(input logic dn);
        logic okf, failf;
        int r0, q0;
        r0 = rises; q0 = readies;
        done_lvl = dn;
        @(negedge clk); end_req = 1'b1;
        @(negedge clk); end_req = 1'b0;
        wait_result(okf, failf);
        chk(rises - r0 == TAILN, "R8 tail pulse count", rises - r0, TAILN);
        chk(cs_b && rdwr_b, "R8 port closed", {cs_b, rdwr_b}, 3);
        chk(readies == q0, "R7 no ready outside transfer", readies - q0, 0);
        if (dn) chk(okf && !failf, "R8 end_ok on done", okf, 1);
        else    chk(failf && !okf, "R9 end_fail on no done", failf, 1);
    endtask

    task automatic t_abort();
        logic okf, failf;
        int r0;
        bit all_ok;
        r0 = rises;
        pulse_begin();
        wait_result(okf, failf);
        chk(rise_at_prog_fall - r0 == ABN, "R10 abort pulse count", rise_at_prog_fall - r0, ABN);
        all_ok = 1;
        for (int i = 0; i < ABN; i++)
            if (!(cap_rdwr[(r0 + i) % 64] && !cap_cs[(r0 + i) % 64])) all_ok = 0;
        chk(all_ok, "R10 rdwr high, cs low during abort", all_ok, 1);
        chk(cs_at_prog_fall, "R10 cs high before prog", cs_at_prog_fall, 1);
        chk(okf, "R4 begin_ok after abort", okf, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_begin_fail();
        t_begin_ok();
        t_stream(5, 8'hA5);
        t_end(1'b1);
        t_begin_ok();
        t_stream(2, 8'h3C);
        t_end(1'b0);
        t_begin_ok();
        t_stream(1, 8'hFF);
        t_abort();
        t_stream(3, 8'h00);
        t_end(1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vecs++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule